// File: doc/BRIEF.md
# Fragment Completion Tracker with Descriptor Cancellation

This block follows every outstanding DMA descriptor from the moment it is registered until its fate is reported. A descriptor occupies one of `SLOTS` tracking slots. It is registered with its owning channel, its 8-bit descriptor tag and the number of fragments it was split into. Each fragment travels to the data mover under a fragment ID whose upper bits give the slot and whose lower bits give the fragment index. The block notes when fragments are issued and counts the successful fragment statuses that come back. When the last fragment of a descriptor is done, it sends one status word to the owning channel.

A channel can also cancel a pending descriptor by writing its tag through a small memory-mapped write port. The block stalls the port with a wait-request and searches all live slots for that channel and tag. It then reports one of three outcomes on the requesting channel's status port: the descriptor was removed before any fragment left, it was removed after some fragments had already been issued, or it was not found. Status ports carry a valid strobe but have no ready, so the receiving channel must take each word in the cycle it appears.

Top module: `cpl_tracker`

## Requirements
- R1: After reset, every `st_valid` bit is low and `waitreq` is low.
- R2: Each status word has its 2-bit code in bits 13:12 and the descriptor tag in bits 7:0, with all other bits zero. Codes: 00 completed, 01 removed before any fragment was issued, 10 removed after some fragments were issued, 11 removal failed. The word goes out on the port of the channel the descriptor was registered with, or of the channel that asked for the cancel.
- R3: A descriptor registered in slot k with F fragments (1 to `SUB_PER`) is reported with code 00 one cycle after the F-th data-mover status with code 00 whose fragment ID (`dm_data` bits 7:0) has slot field k (fragment ID >> log2(`SUB_PER`)). The slot is freed at the same time.
- R4: A data-mover status with a non-zero code in bits 13:12, or one addressed to a free slot, produces no output and does not count toward completion.
- R5: A cancel is accepted when `cs`, `wr` are high and `waitreq` is low. The requesting channel is `addr` bits log2(`NCH`)-1:0, and the tag is `wdata` bits 7:0. Only a live slot registered with both that channel and that tag matches.
- R6: A matched slot gives code 01 if no fragment of it was seen on the issue port (slot field = `issue_sub` >> log2(`SUB_PER`)), and code 10 otherwise. No match gives code 11. A matched slot is freed, so later data-mover statuses for it are ignored.
- R7: `waitreq` is high from the cycle after an accepted cancel until the result is emitted. The search resolves only in a cycle with `dm_valid` low, and its result appears one cycle after it resolves.
- R8: A freed slot can be registered again, and its fragment counts restart from zero.
- R9: At most one status port is valid in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Register a descriptor in a free slot |
| alloc_slot | input | log2(SLOTS) | Slot being registered |
| alloc_chan | input | log2(NCH) | Owning channel |
| alloc_tag | input | 8 | Descriptor tag reported in status |
| alloc_frags | input | log2(SUB_PER)+1 | Number of fragments, 1 to SUB_PER |
| issue_valid | input | 1 | A fragment was handed to the data mover |
| issue_sub | input | log2(SLOTS*SUB_PER) | Fragment ID of the issued fragment |
| dm_valid | input | 1 | Data-mover status strobe |
| dm_data | input | 32 | Data-mover status: code 13:12, fragment ID in low bits |
| cs | input | 1 | Cancel port select |
| wr | input | 1 | Cancel port write |
| addr | input | 14 | Cancel port address; low bits pick the channel |
| wdata | input | 32 | Cancel port data; bits 7:0 are the tag |
| waitreq | output | 1 | Cancel search in progress |
| st_valid | output | NCH | Per-channel status strobe, no backpressure |
| st_data | output | 32*NCH | Per-channel status words, channel c in bits 32c+31:32c |

## Verification
The bench builds the block with its defaults: four channels, 32 slots and eight fragments per descriptor. With these values, the top slot (fragment IDs 248 to 255) and the full eight-fragment count are within reach, as are cancels that name the right tag on the wrong channel. Four channels are enough to show that each result lands on its own port. The eight-bit fragment ID fills the data-mover tag field exactly, so every bit of the slot decode is exercised.

// File: rtl/ct_pkg.sv
`timescale 1ns/1ps
package ct_pkg;
   localparam int TAG_W = 8;
   localparam logic [1:0] CODE_DONE    = 2'b00;
   localparam logic [1:0] CODE_RM_OK   = 2'b01;
   localparam logic [1:0] CODE_RM_PART = 2'b10;
   localparam logic [1:0] CODE_RM_FAIL = 2'b11;

   function automatic logic [31:0] mk_status(input logic [1:0] code,
                                             input logic [TAG_W-1:0] tag);
      logic [31:0] w;
      w        = '0;
      w[13:12] = code;
      w[7:0]   = tag;
      return w;
   endfunction
endpackage

// File: rtl/ct_slot.sv
`timescale 1ns/1ps
module ct_slot #(
   parameter int CH_W  = 2,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic [CH_W-1:0]  alloc_chan,
   input  logic [7:0]       alloc_tag,
   input  logic [CNT_W-1:0] alloc_frags,
   input  logic             issue,
   input  logic             done,
   input  logic             kill,
   output logic             busy,
   output logic             issued,
   output logic [CH_W-1:0]  chan,
   output logic [7:0]       tag,
   output logic             finish
);
   logic [CNT_W-1:0] exp_q, done_q, done_nxt;

   assign done_nxt = done_q + 1'b1;
   assign finish   = busy && done && (done_nxt == exp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         issued <= 1'b0;
         chan   <= '0;
         tag    <= '0;
         exp_q  <= '0;
         done_q <= '0;
      end else if (alloc) begin
         busy   <= 1'b1;
         issued <= 1'b0;
         chan   <= alloc_chan;
         tag    <= alloc_tag;
         exp_q  <= alloc_frags;
         done_q <= '0;
      end else if (busy) begin
         if (kill || finish) begin
            busy <= 1'b0;
         end else begin
            if (done)  done_q <= done_nxt;
            if (issue) issued <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ct_search.sv
`timescale 1ns/1ps
module ct_search #(
   parameter int SLOTS  = 32,
   parameter int CH_W   = 2,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0]           busy,
   input  logic [SLOTS-1:0][CH_W-1:0] chans,
   input  logic [SLOTS-1:0][7:0]      tags,
   input  logic [CH_W-1:0]            req_chan,
   input  logic [7:0]                 req_tag,
   output logic                       found,
   output logic [SLOT_W-1:0]          idx
);
   // lowest matching slot wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = SLOTS - 1; k >= 0; k--) begin
         if (busy[k] && chans[k] == req_chan && tags[k] == req_tag) begin
            found = 1'b1;
            idx   = SLOT_W'(k);
         end
      end
   end
endmodule

// File: rtl/ct_emit.sv
`timescale 1ns/1ps
module ct_emit (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fire,
   input  logic [31:0] word,
   output logic        valid,
   output logic [31:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= fire;
         data  <= fire ? word : '0;
      end
   end
endmodule

// File: rtl/cpl_tracker.sv
`timescale 1ns/1ps
module cpl_tracker #(
   parameter int NCH     = 4,
   parameter int SLOTS   = 32,
   parameter int SUB_PER = 8,
   localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int SPW    = $clog2(SUB_PER),
   localparam int SUB_W  = SLOT_W + SPW,
   localparam int CNT_W  = SPW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [SLOT_W-1:0] alloc_slot,
   input  logic [CH_W-1:0]   alloc_chan,
   input  logic [7:0]        alloc_tag,
   input  logic [CNT_W-1:0]  alloc_frags,
   input  logic              issue_valid,
   input  logic [SUB_W-1:0]  issue_sub,
   input  logic              dm_valid,
   input  logic [31:0]       dm_data,
   input  logic              cs,
   input  logic              wr,
   input  logic [13:0]       addr,
   input  logic [31:0]       wdata,
   output logic              waitreq,
   output logic [NCH-1:0]    st_valid,
   output logic [NCH*32-1:0] st_data
);
   import ct_pkg::*;

   if (NCH < 1 || NCH > 16) begin : g_bad_nch
      $error("cpl_tracker: NCH must be 1..16");
   end
   if (SLOTS < 2 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("cpl_tracker: SLOTS must be a power of two >= 2");
   end
   if (SUB_PER < 2 || (1 << SPW) != SUB_PER) begin : g_bad_sub
      $error("cpl_tracker: SUB_PER must be a power of two >= 2");
   end
   if (SUB_W > 8) begin : g_bad_subw
      $error("cpl_tracker: fragment ID must fit the 8-bit tag field");
   end

   logic [SLOTS-1:0]           s_busy, s_iss, s_fin, s_kill;
   logic [SLOTS-1:0][CH_W-1:0] s_chan;
   logic [SLOTS-1:0][7:0]      s_tag;

   logic                       dm_ok;
   logic [SLOT_W-1:0]          dm_slot, is_slot;
   assign dm_ok   = dm_valid && (dm_data[13:12] == CODE_DONE);
   assign dm_slot = dm_data[SUB_W-1:SPW];
   assign is_slot = issue_sub[SUB_W-1:SPW];

   // cancel request state
   logic              busy_q;
   logic [CH_W-1:0]   rq_chan;
   logic [7:0]        rq_tag;
   logic              accept, resolve, found;
   logic [SLOT_W-1:0] hit_idx;
   logic [1:0]        rm_code;

   assign accept  = cs && wr && !busy_q;
   assign resolve = busy_q && !dm_valid;
   assign waitreq = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rq_chan <= '0;
         rq_tag  <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         rq_chan <= addr[CH_W-1:0];
         rq_tag  <= wdata[7:0];
      end else if (resolve) begin
         busy_q  <= 1'b0;
      end
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign s_kill[k] = resolve && found && (hit_idx == SLOT_W'(k));
      ct_slot #(.CH_W(CH_W), .CNT_W(CNT_W)) i_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc      (alloc_valid && alloc_slot == SLOT_W'(k)),
         .alloc_chan (alloc_chan),
         .alloc_tag  (alloc_tag),
         .alloc_frags(alloc_frags),
         .issue      (issue_valid && is_slot == SLOT_W'(k)),
         .done       (dm_ok && dm_slot == SLOT_W'(k)),
         .kill       (s_kill[k]),
         .busy       (s_busy[k]),
         .issued     (s_iss[k]),
         .chan       (s_chan[k]),
         .tag        (s_tag[k]),
         .finish     (s_fin[k])
      );
   end

   ct_search #(.SLOTS(SLOTS), .CH_W(CH_W)) i_search (
      .busy    (s_busy),
      .chans   (s_chan),
      .tags    (s_tag),
      .req_chan(rq_chan),
      .req_tag (rq_tag),
      .found   (found),
      .idx     (hit_idx)
   );

   assign rm_code = !found ? CODE_RM_FAIL : (s_iss[hit_idx] ? CODE_RM_PART : CODE_RM_OK);

   // one data-mover status per cycle, so only dm_slot can finish
   logic            cpl_fire;
   logic [CH_W-1:0] cpl_chan;
   logic [31:0]     out_word;
   assign cpl_fire = s_fin[dm_slot];
   assign cpl_chan = s_chan[dm_slot];
   assign out_word = resolve ? mk_status(rm_code, rq_tag)
                             : mk_status(CODE_DONE, s_tag[dm_slot]);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      ct_emit i_emit (
         .clk  (clk),
         .rst_n(rst_n),
         .fire ((cpl_fire && cpl_chan == CH_W'(c)) || (resolve && rq_chan == CH_W'(c))),
         .word (out_word),
         .valid(st_valid[c]),
         .data (st_data[c*32 +: 32])
      );
   end

   logic unused_bits;
   assign unused_bits = ^{addr[13:CH_W], wdata[31:8], dm_data[31:14], dm_data[11:SUB_W]};
endmodule

// File: rtl/cpl_tracker_chk.sv
`timescale 1ns/1ps
module cpl_tracker_chk #(
   parameter int NCH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs,
   input logic              wr,
   input logic              waitreq,
   input logic              dm_valid,
   input logic [NCH-1:0]    st_valid,
   input logic [NCH*32-1:0] st_data
);
   // R9
   st_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(st_valid));

   // R7
   wait_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && !waitreq) |=> waitreq);

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (waitreq && dm_valid) |=> waitreq);

   // R7
   out_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|st_valid) |-> $past(dm_valid || waitreq));

   for (genvar c = 0; c < NCH; c++) begin : g_fmt
      // R2
      zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         st_valid[c] |-> (st_data[c*32+14 +: 18] == '0 && st_data[c*32+8 +: 4] == '0));
   end
endmodule

bind cpl_tracker cpl_tracker_chk #(.NCH(NCH)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs      (cs),
   .wr      (wr),
   .waitreq (waitreq),
   .dm_valid(dm_valid),
   .st_valid(st_valid),
   .st_data (st_data)
);

// File: tb/test_cpl_tracker.sv
`timescale 1ns/1ps
module test_cpl_tracker;
   localparam int NCH = 4, SLOTS = 32, SUB_PER = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic alloc_valid = 0; logic [4:0] alloc_slot = 0; logic [1:0] alloc_chan = 0;
   logic [7:0] alloc_tag = 0; logic [3:0] alloc_frags = 0;
   logic issue_valid = 0; logic [7:0] issue_sub = 0;
   logic dm_valid = 0; logic [31:0] dm_data = 0;
   logic cs = 0, wr = 0; logic [13:0] addr = 0; logic [31:0] wdata = 0;
   logic waitreq; logic [NCH-1:0] st_valid; logic [NCH*32-1:0] st_data;

   always #2.5 clk = ~clk;

   cpl_tracker #(.NCH(NCH), .SLOTS(SLOTS), .SUB_PER(SUB_PER)) i_cpl_tracker (.*);

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [39:0] exp_q[$];
   string       exp_r[$];

   task automatic chk(input bit ok, input string r, input string what,
                      input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
      end
   endtask

   task automatic push(input int ch, input logic [1:0] code, input logic [7:0] tag, input string r);
      logic [31:0] w;
      w = '0; w[13:12] = code; w[7:0] = tag;
      exp_q.push_back({8'(ch), w});
      exp_r.push_back(r);
   endtask

   // monitor: compare every emitted word with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         for (int c = 0; c < NCH; c++) begin
            if (st_valid[c]) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R9", "unexpected status", {8'(c), st_data[c*32 +: 32]}, 40'h0);
               end else begin
                  logic [39:0] e; string r;
                  e = exp_q.pop_front(); r = exp_r.pop_front();
                  chk({8'(c), st_data[c*32 +: 32]} == e, r, "status word", {8'(c), st_data[c*32 +: 32]}, e);
               end
            end
         end
      end
   end

   task automatic alloc(input int slot, input int ch, input logic [7:0] tag, input int frags);
      alloc_valid = 1; alloc_slot = 5'(slot); alloc_chan = 2'(ch); alloc_tag = tag; alloc_frags = 4'(frags);
      @(negedge clk); alloc_valid = 0;
   endtask

   task automatic issue(input int sub);
      issue_valid = 1; issue_sub = 8'(sub);
      @(negedge clk); issue_valid = 0;
   endtask

   task automatic dm(input int sub, input logic [1:0] code);
      dm_valid = 1; dm_data = {18'b0, code, 4'b0, 8'(sub)};
      @(negedge clk); dm_valid = 0;
   endtask

   task automatic quiet(input string r);
      chk(st_valid == '0, r, "no status expected", 40'(st_valid), 40'h0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cancel(input int ch, input logic [7:0] tag, input int stall);
      cs = 1; wr = 1; addr = 14'(ch); wdata = {24'hABCDEF, tag};
      @(negedge clk);
      cs = 0; wr = 0;
      chk(waitreq == 1'b1, "R7", "waitreq after accept", 40'(waitreq), 40'h1);
      for (int i = 0; i < stall; i++) begin
         dm_valid = 1; dm_data = {18'b0, 2'b11, 4'b0, 8'd0};
         @(negedge clk);
         chk(waitreq == 1'b1, "R7", "waitreq during stall", 40'(waitreq), 40'h1);
         quiet("R7");
      end
      dm_valid = 0;
      @(negedge clk);
      chk(waitreq == 1'b0, "R7", "waitreq after result", 40'(waitreq), 40'h0);
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(st_valid == '0, "R1", "st_valid in reset", 40'(st_valid), 40'h0);
      chk(waitreq == 1'b0, "R1", "waitreq in reset", 40'(waitreq), 40'h0);
      rst_n = 1;
      @(negedge clk);
      chk(st_valid == '0 && waitreq == 1'b0, "R1", "idle after reset", {st_valid, waitreq}, 40'h0);

      // R3 single fragment
      alloc(0, 0, 8'h11, 1); issue(0);
      push(0, 2'b00, 8'h11, "R3"); dm(0, 2'b00); idle(2);

      // R3 four fragments, no output until the last
      alloc(5, 2, 8'hA5, 4);
      for (int i = 40; i < 44; i++) issue(i);
      dm(40, 2'b00); quiet("R3"); dm(41, 2'b00); quiet("R3"); dm(42, 2'b00); quiet("R3");
      push(2, 2'b00, 8'hA5, "R3"); dm(43, 2'b00); idle(2);

      // R4 non-zero code does not count
      alloc(6, 1, 8'h33, 2);
      dm(48, 2'b10); quiet("R4"); dm(48, 2'b00); quiet("R4");
      push(1, 2'b00, 8'h33, "R4"); dm(49, 2'b00); idle(2);

      // R6 removal before any fragment issued, then later statuses ignored
      alloc(7, 3, 8'h44, 3);
      push(3, 2'b01, 8'h44, "R6"); cancel(3, 8'h44, 0); idle(2);
      dm(56, 2'b00); quiet("R4"); dm(57, 2'b00); quiet("R4"); dm(58, 2'b00); quiet("R4");

      // R6 partial removal
      alloc(8, 1, 8'h55, 2); issue(64); dm(64, 2'b00); quiet("R6");
      push(1, 2'b10, 8'h55, "R6"); cancel(1, 8'h55, 0); idle(2);

      // R6 failed removal: unknown tag
      push(0, 2'b11, 8'h99, "R6"); cancel(0, 8'h99, 0); idle(2);

      // R5 right tag, wrong channel fails; right channel succeeds (with stall, R7)
      alloc(9, 2, 8'h66, 2);
      push(0, 2'b11, 8'h66, "R5"); cancel(0, 8'h66, 0); idle(2);
      push(2, 2'b01, 8'h66, "R5"); cancel(2, 8'h66, 3); idle(2);

      // R8 slot reuse with the full fragment count
      alloc(0, 1, 8'h77, 8);
      for (int i = 0; i < 7; i++) begin dm(i, 2'b00); quiet("R8"); end
      push(1, 2'b00, 8'h77, "R8"); dm(7, 2'b00); idle(2);

      // R3 top slot boundary
      alloc(31, 3, 8'hFE, 1);
      push(3, 2'b00, 8'hFE, "R3"); dm(255, 2'b00); idle(2);

      chk(exp_q.size() == 0, "R2", "all expected words seen", 40'(exp_q.size()), 40'h0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule